// File: doc/BRIEF.md
# Pipeline Interstage Register Set

This block holds the four clocked register banks that sit between the five stages of a load/store pipeline. The stages are fetch, decode, execute, memory and writeback. Every value an instruction needs later is carried forward with that instruction, one bank per clock. This covers data words, control flags and the destination register number. The surrounding logic is outside the block: fetch, decode, ALU, data memory and register file. Each of those reads its operands from the bank in front of it and drives its results into the bank behind it.

Control flags are packed in groups, one for the execute stage, one for the memory stage and one for the writeback stage. A group is dropped once its stage has used it. A memory-write enable decoded for a store therefore reaches the data memory only when the store itself occupies the memory stage. The register file likewise receives its write enable and destination number from the last bank, never from decode. The pipeline never stalls, so the banks load on every clock. There is no valid/ready handshake and no back-pressure: each stage must accept a new instruction every cycle. A synchronous reset fills every bank with harmless bubbles.

Top module: `pipe_interstage_regs`

## Requirements
- R1: `id_instr` and `id_pc4` show, one cycle later, the values on `if_instr` and `if_pc4`.
- R2: One cycle after decode, the execute outputs show the instruction's data. `ex_pc4` is the PC+4 held for it. `ex_rs_val`, `ex_rt_val`, `ex_dest` and `ex_ctl` repeat the decode inputs unchanged. `ex_imm_ext` is `id_imm` sign-extended, with bit 15 copied into bits 31:16.
- R3: One cycle after execute, `mem_br_target`, `mem_zero` and `mem_addr` show that instruction's `ex_br_target`, `ex_zero` and `ex_alu_res`. `mem_wdata` shows the `id_rt_val` that was decoded for the same instruction two cycles before.
- R4: `mem_we`, `mem_re` and `mem_branch` are high exactly in the cycle two after the instruction that set `id_mem_write`, `id_mem_read` or `id_branch` was decoded. A store in decode never raises `mem_we` while an earlier instruction is in the memory stage.
- R5: `mem_pc_src` is high only when the instruction in the memory stage has its branch flag set and its zero flag set.
- R6: `wb_we` and `wb_dest` come from the same instruction. They appear three cycles after its decode, which is four cycles after its fetch.
- R7: `wb_data` equals the `mem_rdata` captured for the writeback instruction when its mem-to-reg flag is set. Otherwise it equals that instruction's ALU result.
- R8: In the first cycle after a clock edge with `rst` high, all control outputs are zero. These are `ex_ctl`, `mem_we`, `mem_re`, `mem_branch`, `mem_pc_src` and `wb_we`. This holds even if the control inputs were all ones during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all banks load on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears control flags |
| if_instr | input | 32 | Instruction word from fetch |
| if_pc4 | input | 32 | Incremented PC from fetch |
| id_instr | output | 32 | Instruction word seen by decode |
| id_pc4 | output | 32 | PC+4 seen by decode |
| id_rs_val | input | 32 | First register read value |
| id_rt_val | input | 32 | Second register read value |
| id_imm | input | 16 | Raw immediate field |
| id_dest | input | 5 | Destination register number |
| id_ex_ctl | input | 4 | Opaque execute-stage control group |
| id_branch | input | 1 | Branch flag |
| id_mem_read | input | 1 | Load flag |
| id_mem_write | input | 1 | Store flag |
| id_reg_write | input | 1 | Register write flag |
| id_mem_to_reg | input | 1 | Writeback source select |
| ex_pc4 | output | 32 | PC+4 for execute |
| ex_rs_val | output | 32 | First operand for execute |
| ex_rt_val | output | 32 | Second register value for execute |
| ex_imm_ext | output | 32 | Sign-extended immediate |
| ex_dest | output | 5 | Destination number in execute |
| ex_ctl | output | 4 | Execute-stage control group |
| ex_br_target | input | 32 | Computed branch target |
| ex_zero | input | 1 | ALU zero flag |
| ex_alu_res | input | 32 | ALU result |
| mem_br_target | output | 32 | Branch target in memory stage |
| mem_zero | output | 1 | Zero flag in memory stage |
| mem_addr | output | 32 | Data memory address (ALU result) |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Data memory write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_branch | output | 1 | Branch flag in memory stage |
| mem_pc_src | output | 1 | Take-branch select back to fetch |
| mem_rdata | input | 32 | Data memory read value |
| wb_we | output | 1 | Register file write enable |
| wb_dest | output | 5 | Register file write number |
| wb_data | output | 32 | Register file write data |

## Verification
An instruction fetched in cycle t appears at the decode outputs in t+1 and at the execute outputs in t+2. It reaches the memory-stage outputs in t+3 and the writeback outputs in t+4. The bench plays the outside stages on that schedule, driving each stage's inputs for the instruction it holds in that cycle. After every rising edge it computes from the instruction index what each bank must show and compares every output. Control outputs are checked in every cycle, including bubble cycles, so a store enable that arrives a cycle early or late shows up as a mismatch. The stream runs through add, sub, or, store, load and branch patterns, with immediates of both signs.

// File: rtl/pipe_regs_pkg.sv
package pipe_regs_pkg;

  // memory-stage control group
  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  // writeback-stage control group
  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctl_t;

  localparam mem_ctl_t MEM_CTL_NOP = '{branch: 1'b0, mem_read: 1'b0, mem_write: 1'b0};
  localparam wb_ctl_t  WB_CTL_NOP  = '{reg_write: 1'b0, mem_to_reg: 1'b0};

endpackage

// File: rtl/if_id_bank.sv
module if_id_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic [XLEN-1:0] instr_d,
  input  logic [XLEN-1:0] pc4_d,
  output logic [XLEN-1:0] instr_q,
  output logic [XLEN-1:0] pc4_q
);
  // fetch results carry no control, so nothing here needs clearing
  always_ff @(posedge clk) begin
    instr_q <= instr_d;
    pc4_q   <= pc4_d;
  end
endmodule

// File: rtl/id_ex_bank.sv
module id_ex_bank
  import pipe_regs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int RADDR_W = 5,
  parameter int EXC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    pc4_d,
  input  logic [XLEN-1:0]    rs_d,
  input  logic [XLEN-1:0]    rt_d,
  input  logic [IMM_W-1:0]   imm_d,
  input  logic [RADDR_W-1:0] dest_d,
  input  logic [EXC_W-1:0]   exc_d,
  input  mem_ctl_t           memc_d,
  input  wb_ctl_t            wbc_d,
  output logic [XLEN-1:0]    pc4_q,
  output logic [XLEN-1:0]    rs_q,
  output logic [XLEN-1:0]    rt_q,
  output logic [XLEN-1:0]    imm_q,
  output logic [RADDR_W-1:0] dest_q,
  output logic [EXC_W-1:0]   exc_q,
  output mem_ctl_t           memc_q,
  output wb_ctl_t            wbc_q
);
  logic [XLEN-1:0] imm_wide;

  generate
    if (XLEN > IMM_W) begin : g_sext
      assign imm_wide = {{(XLEN-IMM_W){imm_d[IMM_W-1]}}, imm_d};
    end else begin : g_trunc
      assign imm_wide = imm_d[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    pc4_q  <= pc4_d;
    rs_q   <= rs_d;
    rt_q   <= rt_d;
    imm_q  <= imm_wide;
    dest_q <= dest_d;
  end

  // all three control groups ride in this bank; reset turns them into a bubble
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q  <= '0;
      memc_q <= MEM_CTL_NOP;
      wbc_q  <= WB_CTL_NOP;
    end else begin
      exc_q  <= exc_d;
      memc_q <= memc_d;
      wbc_q  <= wbc_d;
    end
  end
endmodule

// File: rtl/ex_mem_bank.sv
module ex_mem_bank
  import pipe_regs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    tgt_d,
  input  logic               zero_d,
  input  logic [XLEN-1:0]    alu_d,
  input  logic [XLEN-1:0]    rt_d,
  input  logic [RADDR_W-1:0] dest_d,
  input  mem_ctl_t           memc_d,
  input  wb_ctl_t            wbc_d,
  output logic [XLEN-1:0]    tgt_q,
  output logic               zero_q,
  output logic [XLEN-1:0]    alu_q,
  output logic [XLEN-1:0]    rt_q,
  output logic [RADDR_W-1:0] dest_q,
  output mem_ctl_t           memc_q,
  output wb_ctl_t            wbc_q
);
  always_ff @(posedge clk) begin
    tgt_q  <= tgt_d;
    zero_q <= zero_d;
    alu_q  <= alu_d;
    rt_q   <= rt_d;
    dest_q <= dest_d;
  end

  // execute group already consumed; only memory and writeback groups remain
  always_ff @(posedge clk) begin
    if (rst) begin
      memc_q <= MEM_CTL_NOP;
      wbc_q  <= WB_CTL_NOP;
    end else begin
      memc_q <= memc_d;
      wbc_q  <= wbc_d;
    end
  end
endmodule

// File: rtl/mem_wb_bank.sv
module mem_wb_bank
  import pipe_regs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    rdata_d,
  input  logic [XLEN-1:0]    alu_d,
  input  logic [RADDR_W-1:0] dest_d,
  input  wb_ctl_t            wbc_d,
  output logic               we_q,
  output logic [RADDR_W-1:0] dest_q,
  output logic [XLEN-1:0]    data_q
);
  logic [XLEN-1:0] rdata_r;
  logic [XLEN-1:0] alu_r;
  wb_ctl_t         wbc_r;

  always_ff @(posedge clk) begin
    rdata_r <= rdata_d;
    alu_r   <= alu_d;
    dest_q  <= dest_d;
  end

  always_ff @(posedge clk) begin
    if (rst) wbc_r <= WB_CTL_NOP;
    else     wbc_r <= wbc_d;
  end

  // writeback source select: loaded word or ALU result
  always_comb begin
    data_q = wbc_r.mem_to_reg ? rdata_r : alu_r;
    we_q   = wbc_r.reg_write;
  end
endmodule

// File: rtl/pipe_interstage_regs.sv
module pipe_interstage_regs
  import pipe_regs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int RADDR_W = 5,
  parameter int EXC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    if_instr,
  input  logic [XLEN-1:0]    if_pc4,
  output logic [XLEN-1:0]    id_instr,
  output logic [XLEN-1:0]    id_pc4,
  input  logic [XLEN-1:0]    id_rs_val,
  input  logic [XLEN-1:0]    id_rt_val,
  input  logic [IMM_W-1:0]   id_imm,
  input  logic [RADDR_W-1:0] id_dest,
  input  logic [EXC_W-1:0]   id_ex_ctl,
  input  logic               id_branch,
  input  logic               id_mem_read,
  input  logic               id_mem_write,
  input  logic               id_reg_write,
  input  logic               id_mem_to_reg,
  output logic [XLEN-1:0]    ex_pc4,
  output logic [XLEN-1:0]    ex_rs_val,
  output logic [XLEN-1:0]    ex_rt_val,
  output logic [XLEN-1:0]    ex_imm_ext,
  output logic [RADDR_W-1:0] ex_dest,
  output logic [EXC_W-1:0]   ex_ctl,
  input  logic [XLEN-1:0]    ex_br_target,
  input  logic               ex_zero,
  input  logic [XLEN-1:0]    ex_alu_res,
  output logic [XLEN-1:0]    mem_br_target,
  output logic               mem_zero,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  output logic               mem_we,
  output logic               mem_re,
  output logic               mem_branch,
  output logic               mem_pc_src,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               wb_we,
  output logic [RADDR_W-1:0] wb_dest,
  output logic [XLEN-1:0]    wb_data
);
  mem_ctl_t memc_id, memc_ex, memc_mem;
  wb_ctl_t  wbc_id, wbc_ex, wbc_mem;
  logic [RADDR_W-1:0] dest_mem;

  assign memc_id = '{branch: id_branch, mem_read: id_mem_read, mem_write: id_mem_write};
  assign wbc_id  = '{reg_write: id_reg_write, mem_to_reg: id_mem_to_reg};

  if_id_bank #(.XLEN(XLEN)) u_if_id (
    .clk     (clk),
    .instr_d (if_instr),
    .pc4_d   (if_pc4),
    .instr_q (id_instr),
    .pc4_q   (id_pc4)
  );

  id_ex_bank #(.XLEN(XLEN), .IMM_W(IMM_W), .RADDR_W(RADDR_W), .EXC_W(EXC_W)) u_id_ex (
    .clk    (clk),
    .rst    (rst),
    .pc4_d  (id_pc4),
    .rs_d   (id_rs_val),
    .rt_d   (id_rt_val),
    .imm_d  (id_imm),
    .dest_d (id_dest),
    .exc_d  (id_ex_ctl),
    .memc_d (memc_id),
    .wbc_d  (wbc_id),
    .pc4_q  (ex_pc4),
    .rs_q   (ex_rs_val),
    .rt_q   (ex_rt_val),
    .imm_q  (ex_imm_ext),
    .dest_q (ex_dest),
    .exc_q  (ex_ctl),
    .memc_q (memc_ex),
    .wbc_q  (wbc_ex)
  );

  ex_mem_bank #(.XLEN(XLEN), .RADDR_W(RADDR_W)) u_ex_mem (
    .clk    (clk),
    .rst    (rst),
    .tgt_d  (ex_br_target),
    .zero_d (ex_zero),
    .alu_d  (ex_alu_res),
    .rt_d   (ex_rt_val),
    .dest_d (ex_dest),
    .memc_d (memc_ex),
    .wbc_d  (wbc_ex),
    .tgt_q  (mem_br_target),
    .zero_q (mem_zero),
    .alu_q  (mem_addr),
    .rt_q   (mem_wdata),
    .dest_q (dest_mem),
    .memc_q (memc_mem),
    .wbc_q  (wbc_mem)
  );

  assign mem_we     = memc_mem.mem_write;
  assign mem_re     = memc_mem.mem_read;
  assign mem_branch = memc_mem.branch;
  assign mem_pc_src = memc_mem.branch & mem_zero;

  mem_wb_bank #(.XLEN(XLEN), .RADDR_W(RADDR_W)) u_mem_wb (
    .clk     (clk),
    .rst     (rst),
    .rdata_d (mem_rdata),
    .alu_d   (mem_addr),
    .dest_d  (dest_mem),
    .wbc_d   (wbc_mem),
    .we_q    (wb_we),
    .dest_q  (wb_dest),
    .data_q  (wb_data)
  );

  // cycles since reset released, saturating, so $past never reaches into reset
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R4: a memory write belongs to the instruction decoded two cycles earlier
  p_store_in_own_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && mem_we) |-> $past(id_mem_write, 2));

  // R5: take-branch only for a branch decoded two cycles earlier
  p_pc_src_origin_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && mem_pc_src) |-> $past(id_branch, 2));

  // R6: register write enable follows its instruction through three banks
  p_wb_enable_origin_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && wb_we) |-> $past(id_reg_write, 3));

  // R6: write number matches the one decoded with that enable
  p_wb_dest_origin_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && wb_we) |-> (wb_dest == $past(id_dest, 3)));

  // R8: a reset edge leaves every control output in the bubble state
  p_reset_bubble_r8: assert property (@(posedge clk)
    rst |=> (ex_ctl == '0 && !mem_we && !mem_re && !mem_branch && !mem_pc_src && !wb_we));

endmodule

// File: tb/pipe_interstage_regs_bench.sv
module pipe_interstage_regs_bench;
  localparam int N = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] if_instr, if_pc4, id_instr, id_pc4;
  logic [31:0] id_rs_val, id_rt_val;
  logic [15:0] id_imm;
  logic [4:0]  id_dest;
  logic [3:0]  id_ex_ctl;
  logic id_branch, id_mem_read, id_mem_write, id_reg_write, id_mem_to_reg;
  logic [31:0] ex_pc4, ex_rs_val, ex_rt_val, ex_imm_ext;
  logic [4:0]  ex_dest;
  logic [3:0]  ex_ctl;
  logic [31:0] ex_br_target, ex_alu_res;
  logic        ex_zero;
  logic [31:0] mem_br_target, mem_addr, mem_wdata, mem_rdata;
  logic mem_zero, mem_we, mem_re, mem_branch, mem_pc_src;
  logic wb_we;
  logic [4:0]  wb_dest;
  logic [31:0] wb_data;

  pipe_interstage_regs u_pipe_interstage_regs (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // instruction kinds: 0 add, 1 sub, 2 or, 3 store, 4 load, 5 branch
  function automatic int kind(int k); return k % 6; endfunction
  function automatic bit ok(int k); return (k >= 0) && (k < N); endfunction
  function automatic logic [31:0] f_instr(int k); return 32'h0100_0000 * kind(k) + 32'(k) * 32'h1357; endfunction
  function automatic logic [31:0] f_pc4(int k); return 32'(4 * k + 4); endfunction
  function automatic logic [31:0] f_rs(int k); return (32'(k) * 32'h0101_0101) ^ 32'hA5; endfunction
  function automatic logic [31:0] f_rt(int k); return 32'(k * 7 + 3); endfunction
  function automatic logic [15:0] f_imm(int k); return 16'(k * 499) ^ ((k % 2 == 1) ? 16'h8000 : 16'h0); endfunction
  function automatic logic [31:0] f_ext(int k); return 32'($signed(f_imm(k))); endfunction
  function automatic logic [4:0]  f_dest(int k); return 5'((k * 5 + 1) % 32); endfunction
  function automatic logic [3:0]  f_exc(int k); return ok(k) ? 4'(kind(k) + 1) : 4'h0; endfunction
  function automatic logic [31:0] f_tgt(int k); return f_pc4(k) + (f_ext(k) << 2); endfunction
  function automatic logic f_zero(int k); return (k % 3 == 0); endfunction
  function automatic logic [31:0] f_alu(int k); return f_rs(k) + 32'(k); endfunction
  function automatic logic [31:0] f_rdata(int k); return ~f_alu(k); endfunction
  function automatic logic f_br(int k);  return ok(k) && kind(k) == 5; endfunction
  function automatic logic f_rd(int k);  return ok(k) && kind(k) == 4; endfunction
  function automatic logic f_wr(int k);  return ok(k) && kind(k) == 3; endfunction
  function automatic logic f_rw(int k);  return ok(k) && (kind(k) <= 2 || kind(k) == 4); endfunction
  function automatic logic f_m2r(int k); return ok(k) && kind(k) == 4; endfunction

  task automatic chk(string req, int t, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", req, t, got, exp);
    end
  endtask

  task automatic drive(int t);
    int kd = t - 1, ke = t - 2, km = t - 3;
    if_instr = ok(t) ? f_instr(t) : 32'h0;
    if_pc4   = ok(t) ? f_pc4(t) : 32'h0;
    id_rs_val = f_rs(kd); id_rt_val = f_rt(kd); id_imm = f_imm(kd); id_dest = f_dest(kd);
    if (t < 0) begin
      // garbage control during reset: reset must still clear it
      id_ex_ctl = 4'hF; id_branch = 1; id_mem_read = 1; id_mem_write = 1;
      id_reg_write = 1; id_mem_to_reg = 1;
    end else begin
      id_ex_ctl = f_exc(kd); id_branch = f_br(kd); id_mem_read = f_rd(kd);
      id_mem_write = f_wr(kd); id_reg_write = f_rw(kd); id_mem_to_reg = f_m2r(kd);
    end
    ex_br_target = f_tgt(ke); ex_zero = f_zero(ke); ex_alu_res = f_alu(ke);
    mem_rdata = f_rdata(km);
    rst = (t < 0);
  endtask

  task automatic check(int t);
    int kd = t - 1, ke = t - 2, km = t - 3, kw = t - 4;
    string rc = (t == 0) ? "R8" : "R4";
    if (ok(kd)) begin
      chk("R1 instr", t, id_instr, f_instr(kd));
      chk("R1 pc4", t, id_pc4, f_pc4(kd));
    end
    if (ok(ke)) begin
      chk("R2 pc4", t, ex_pc4, f_pc4(ke));
      chk("R2 rs", t, ex_rs_val, f_rs(ke));
      chk("R2 rt", t, ex_rt_val, f_rt(ke));
      chk("R2 imm_ext", t, ex_imm_ext, f_ext(ke));
      chk("R2 dest", t, 32'(ex_dest), 32'(f_dest(ke)));
    end
    chk((t == 0) ? "R8 ex_ctl" : "R2 ex_ctl", t, 32'(ex_ctl), 32'(f_exc(ke)));
    if (ok(km)) begin
      chk("R3 target", t, mem_br_target, f_tgt(km));
      chk("R3 zero", t, 32'(mem_zero), 32'(f_zero(km)));
      chk("R3 addr", t, mem_addr, f_alu(km));
      chk("R3 wdata", t, mem_wdata, f_rt(km));
    end
    chk({rc, " mem_we"}, t, 32'(mem_we), 32'(f_wr(km)));
    chk({rc, " mem_re"}, t, 32'(mem_re), 32'(f_rd(km)));
    chk({rc, " mem_branch"}, t, 32'(mem_branch), 32'(f_br(km)));
    chk((t == 0) ? "R8 pc_src" : "R5 pc_src", t, 32'(mem_pc_src), 32'(f_br(km) && f_zero(km)));
    chk((t == 0) ? "R8 wb_we" : "R6 wb_we", t, 32'(wb_we), 32'(f_rw(kw)));
    if (ok(kw)) begin
      chk("R6 wb_dest", t, 32'(wb_dest), 32'(f_dest(kw)));
      chk("R7 wb_data", t, wb_data, f_m2r(kw) ? f_rdata(kw) : f_alu(kw));
    end
  endtask

  initial begin
    drive(-3);
    for (int t = -2; t <= N + 4; t++) begin
      @(negedge clk);
      if (t >= 0) check(t);
      drive(t);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule